// File: doc/BRIEF.md
# Elapsed Time Counter with Alarm

This block keeps a free-running 48-bit count of 32768 Hz reference ticks and compares it against a programmable 48-bit alarm value. Software reaches both values through a 16-bit word register bus. Each 48-bit value is split into three words. Because the reference runs at 32768 Hz, the whole-second count sits in bits 47:15 of the counter.

A second register bank holds an interrupt status word. Bit 0 of that word is a sticky alarm flag, and software clears it by writing a one. The interrupt output is the flag gated by an enable input.

The three counter words are not captured together. A reader that needs a consistent 48-bit value reads all three words twice and retries if the two reads differ. The block keeps this behaviour: it adds no snapshot register.

Top module: `elapsed_alarm`

## Requirements
- R1: After reset, every counter word, every compare word and the status word read as zero, and `irqOut` is low.
- R2: In a cycle with `tickEn` high and no counter write, the counter increases by one at the clock edge. In other cycles it holds.
  - In bank 0 the counter words are read at byte offsets 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32).
  - Reads are combinational from the live count, with no latching between words.
- R3: A write to one counter word loads that word's 16 bits at the clock edge and leaves the other words unchanged.
  - A tick that arrives in the same cycle as a counter write is dropped.
  - Counting resumes from the loaded value on the next tick.
- R4: An increment carries across the 16-bit word boundaries. An all-ones counter wraps to zero.
- R5: The compare words are at bank 0 offsets 0x08, 0x0A and 0x0C, with the same bit alignment as the counter. They read back the value last written, and writing them does not change the counter.
- R6: The alarm flag (bank 1, offset 0x1E, bit 0) is set at the clock edge of a tick cycle in which the counter equals a nonzero compare value.
  - Equality in a cycle without a tick does not set the flag.
- R7: A compare value of all zeros never sets the flag, even when the counter passes through zero.
- R8: The flag stays set until it is cleared. Writing a one to bit 0 of the status word clears it. Writing a zero to bit 0 leaves it unchanged. If a set and a clear fall in the same cycle, the flag ends up set.
- R9: `irqOut` equals the flag ANDed with `alarmIntEn`. A low enable masks the output, but the flag still sets.
- R10: Offsets that are not mapped read as zero, and writes to them change nothing. Status bits 15:1 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse per 32768 Hz reference tick |
| bankSel | input | 1 | 0 selects the counter/compare bank, 1 selects the status bank |
| busAddr | input | 5 | Byte offset within the selected bank |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `bankSel`/`busAddr`, combinational |
| alarmIntEn | input | 1 | Enable for the alarm interrupt |
| irqOut | output | 1 | Alarm interrupt request |

## Verification
A counter register that is corrupted or misses an increment shows up on the very next combinational read of the affected word. A carry fault shows up only when the lower word rolls over, so the bench sets words just below their rollover points. A wrong comparison, or a tick qualifier that is lost, appears at the status word and at `irqOut` one edge after the matching tick. The bench therefore also watches cycles in which the counter equals the compare value without a tick, which exposes a flag that sets too early.

// File: rtl/elapsed_pkg.sv
package elapsed_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CNT,
    RD_CMP,
    RD_STS
  } rdKind_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic             wrCnt;
    logic             wrCmp;
    logic             wrSts;
    rdKind_e          rdKind;
    logic [IDX_W-1:0] wordIdx;
  } ctlStrobes_t;

endpackage

// File: rtl/elapsed_ctrl.sv
module elapsed_ctrl
  import elapsed_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int NWORDS   = 3,
  parameter int CNT_BASE = 'h00,
  parameter int CMP_BASE = 'h08,
  parameter int STS_OFS  = 'h1E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bankSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output ctlStrobes_t       strobes
);

  logic [NWORDS-1:0] cntHit;
  logic [NWORDS-1:0] cmpHit;
  logic              stsHit;

  genvar gi;
  generate
    for (gi = 0; gi < NWORDS; gi++) begin : gWordDec
      assign cntHit[gi] = !bankSel && (busAddr == ADDR_W'(CNT_BASE + 2 * gi));
      assign cmpHit[gi] = !bankSel && (busAddr == ADDR_W'(CMP_BASE + 2 * gi));
    end
  endgenerate

  assign stsHit = bankSel && (busAddr == ADDR_W'(STS_OFS));

  always_comb begin
    strobes         = '0;
    strobes.rdKind  = RD_NONE;
    for (int i = 0; i < NWORDS; i++) begin
      if (cntHit[i] || cmpHit[i]) strobes.wordIdx = IDX_W'(i);
    end
    if (|cntHit)     strobes.rdKind = RD_CNT;
    else if (|cmpHit) strobes.rdKind = RD_CMP;
    else if (stsHit)  strobes.rdKind = RD_STS;
    strobes.wrCnt = busWr && (|cntHit);
    strobes.wrCmp = busWr && (|cmpHit);
    strobes.wrSts = busWr && stsHit;
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCnt, strobes.wrCmp, strobes.wrSts})); // R10

  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> !(strobes.wrCnt || strobes.wrCmp || strobes.wrSts)); // R10

endmodule

// File: rtl/elapsed_dpath.sv
module elapsed_dpath
  import elapsed_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [WORD_W-1:0] busWdata,
  input  ctlStrobes_t       strobes,
  input  logic              alarmIntEn,
  output logic [WORD_W-1:0] busRdata,
  output logic              irqOut
);

  localparam int NWORDS = CNT_W / WORD_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic             alarmSts;
  logic [NWORDS-1:0][WORD_W-1:0] cntLoad;
  logic [NWORDS-1:0][WORD_W-1:0] cmpLoad;
  logic [NWORDS-1:0][WORD_W-1:0] cntView;
  logic [NWORDS-1:0][WORD_W-1:0] cmpView;
  logic             alarmHit;
  logic             stsClr;

  assign cntView = cnt;
  assign cmpView = cmp;

  genvar gi;
  generate
    for (gi = 0; gi < NWORDS; gi++) begin : gWordLoad
      assign cntLoad[gi] = (strobes.wrCnt && strobes.wordIdx == IDX_W'(gi))
                           ? busWdata : cntView[gi];
      assign cmpLoad[gi] = (strobes.wrCmp && strobes.wordIdx == IDX_W'(gi))
                           ? busWdata : cmpView[gi];
    end
  endgenerate

  assign alarmHit = tickEn && (cnt == cmp) && (cmp != '0);
  assign stsClr   = strobes.wrSts && busWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      cmp      <= '0;
      alarmSts <= 1'b0;
    end else begin
      if (strobes.wrCnt)  cnt <= cntLoad;
      else if (tickEn)    cnt <= cnt + CNT_W'(1);
      if (strobes.wrCmp)  cmp <= cmpLoad;
      if (alarmHit)       alarmSts <= 1'b1;
      else if (stsClr)    alarmSts <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (strobes.rdKind)
      RD_CNT: for (int i = 0; i < NWORDS; i++)
                if (strobes.wordIdx == IDX_W'(i)) busRdata = cntView[i];
      RD_CMP: for (int i = 0; i < NWORDS; i++)
                if (strobes.wordIdx == IDX_W'(i)) busRdata = cmpView[i];
      RD_STS: busRdata = {{(WORD_W-1){1'b0}}, alarmSts};
      default: busRdata = '0;
    endcase
  end

  assign irqOut = alarmSts & alarmIntEn;

  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strobes.wrCnt) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobes.wrCnt) |=> $stable(cnt)); // R2

  AST_CMP_WRITE_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrCmp && !tickEn) |=> $stable(cnt)); // R5

  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cnt == cmp && cmp != '0) |=> alarmSts); // R6

  AST_NO_SPURIOUS_ALARM: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmSts && (!tickEn || cmp == '0)) |=> !alarmSts); // R7

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (alarmSts && !(strobes.wrSts && busWdata[0])) |=> alarmSts); // R8

endmodule

// File: rtl/elapsed_alarm.sv
module elapsed_alarm
  import elapsed_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              bankSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic              alarmIntEn,
  output logic              irqOut
);

  localparam int NWORDS = CNT_W / WORD_W;

  ctlStrobes_t strobes;

  elapsed_ctrl #(
    .ADDR_W  (ADDR_W),
    .NWORDS  (NWORDS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .bankSel (bankSel),
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobes (strobes)
  );

  elapsed_dpath #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .busWdata   (busWdata),
    .strobes    (strobes),
    .alarmIntEn (alarmIntEn),
    .busRdata   (busRdata),
    .irqOut     (irqOut)
  );

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !alarmIntEn |-> !irqOut); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !irqOut); // R1

endmodule

// File: tb/sim_elapsed_alarm.sv
module sim_elapsed_alarm;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        bankSel = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        alarmIntEn = 1'b0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  elapsed_alarm u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .bankSel(bankSel),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .alarmIntEn(alarmIntEn), .irqOut(irqOut)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock cycle with the given inputs; called at a negative edge
  task automatic step(logic bank, logic [4:0] addr, logic wr,
                      logic [15:0] data, logic tick);
    bankSel = bank; busAddr = addr; busWr = wr; busWdata = data; tickEn = tick;
    @(negedge clk);
    busWr = 1'b0; tickEn = 1'b0;
  endtask

  task automatic wr(logic bank, logic [4:0] addr, logic [15:0] data);
    step(bank, addr, 1'b1, data, 1'b0);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) step(1'b0, 5'h00, 1'b0, 16'h0, 1'b1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 5'h00, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic rd(logic bank, logic [4:0] addr, output logic [15:0] v);
    bankSel = bank; busAddr = addr; busWr = 1'b0;
    #1 v = busRdata;
  endtask

  task automatic rdCnt(output logic [47:0] v);
    logic [15:0] lo, mi, hi;
    rd(0, 5'h00, lo); rd(0, 5'h02, mi); rd(0, 5'h04, hi);
    v = {hi, mi, lo};
  endtask

  task automatic rdCmp(output logic [47:0] v);
    logic [15:0] lo, mi, hi;
    rd(0, 5'h08, lo); rd(0, 5'h0A, mi); rd(0, 5'h0C, hi);
    v = {hi, mi, lo};
  endtask

  task automatic setCnt(logic [47:0] v);
    wr(0, 5'h00, v[15:0]); wr(0, 5'h02, v[31:16]); wr(0, 5'h04, v[47:32]);
  endtask

  task automatic setCmp(logic [47:0] v);
    wr(0, 5'h08, v[15:0]); wr(0, 5'h0A, v[31:16]); wr(0, 5'h0C, v[47:32]);
  endtask

  task automatic rdSts(output logic [15:0] v);
    rd(1, 5'h1E, v);
  endtask

  task automatic tReset();
    logic [47:0] v; logic [15:0] s;
    rdCnt(v); check("R1 counter", v, 0);
    rdCmp(v); check("R1 compare", v, 0);
    rdSts(s); check("R1 status", s, 0);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic tCount();
    logic [47:0] v;
    tick(5); idle(2);
    rdCnt(v); check("R2 five ticks", v, 5);
    idle(4);
    rdCnt(v); check("R2 hold without tick", v, 5);
  endtask

  task automatic tLoad();
    logic [47:0] v;
    setCnt(48'h1234_5678_9ABC);
    rdCnt(v); check("R3 full load", v, 48'h1234_5678_9ABC);
    wr(0, 5'h02, 16'hBEEF);
    rdCnt(v); check("R3 single word", v, 48'h1234_BEEF_9ABC);
    step(0, 5'h00, 1'b1, 16'h0010, 1'b1);
    rdCnt(v); check("R3 tick dropped on write", v, 48'h1234_BEEF_0010);
    tick(1);
    rdCnt(v); check("R3 resume from load", v, 48'h1234_BEEF_0011);
  endtask

  task automatic tCarry();
    logic [47:0] v;
    setCnt(48'h0000_0000_FFFF); tick(1);
    rdCnt(v); check("R4 low carry", v, 48'h0000_0001_0000);
    setCnt(48'h0000_FFFF_FFFF); tick(1);
    rdCnt(v); check("R4 mid carry", v, 48'h0001_0000_0000);
    setCnt(48'hFFFF_FFFF_FFFF); tick(1);
    rdCnt(v); check("R4 wrap", v, 0);
  endtask

  task automatic tCompareRegs();
    logic [47:0] v;
    setCnt(48'h0000_0000_0777);
    setCmp(48'hA5A5_5A5A_0F0F);
    rdCmp(v); check("R5 readback", v, 48'hA5A5_5A5A_0F0F);
    rdCnt(v); check("R5 counter untouched", v, 48'h0000_0000_0777);
  endtask

  task automatic tAlarm();
    logic [15:0] s;
    alarmIntEn = 1'b1;
    setCmp(48'h0000_0000_0005);
    setCnt(48'h0000_0000_0003);
    tick(2); idle(3);
    rdSts(s); check("R6 equal without tick", s, 0);
    check("R9 irq idle", irqOut, 0);
    tick(1);
    rdSts(s); check("R6 set on tick match", s, 1);
    check("R9 irq follows flag", irqOut, 1);
    idle(3);
    rdSts(s); check("R8 sticky", s, 1);
    wr(1, 5'h1E, 16'hFFFE);
    rdSts(s); check("R8 zero write keeps", s, 1);
    wr(1, 5'h1E, 16'h0001);
    rdSts(s); check("R8 write one clears", s, 0);
    check("R9 irq drops", irqOut, 0);
  endtask

  task automatic tSetWins();
    logic [15:0] s;
    setCnt(48'h0000_0000_0005);
    step(1, 5'h1E, 1'b1, 16'h0001, 1'b1);
    rdSts(s); check("R8 set beats clear", s, 1);
    wr(1, 5'h1E, 16'h0001);
  endtask

  task automatic tMask();
    logic [15:0] s;
    alarmIntEn = 1'b0;
    setCmp(48'h0000_0002_0000);
    setCnt(48'h0000_0002_0000);
    tick(1);
    rdSts(s); check("R9 flag sets while masked", s, 1);
    check("R9 irq masked", irqOut, 0);
    alarmIntEn = 1'b1; #1;
    check("R9 irq unmasked", irqOut, 1);
    wr(1, 5'h1E, 16'h0001);
  endtask

  task automatic tZeroCmp();
    logic [15:0] s;
    setCmp(48'h0);
    setCnt(48'hFFFF_FFFF_FFFE);
    tick(4);
    rdSts(s); check("R7 zero compare silent", s, 0);
    check("R7 irq", irqOut, 0);
  endtask

  task automatic tUnmapped();
    logic [47:0] v; logic [15:0] s;
    setCnt(48'h0000_0000_0042);
    setCmp(48'h0000_0000_0099);
    wr(0, 5'h06, 16'hFFFF);
    wr(0, 5'h0E, 16'hFFFF);
    wr(1, 5'h00, 16'hFFFF);
    rd(0, 5'h06, s); check("R10 hole reads zero", s, 0);
    rd(1, 5'h04, s); check("R10 bank1 hole", s, 0);
    rd(0, 5'h1E, s); check("R10 status offset in bank0", s, 0);
    rdCnt(v); check("R10 counter unchanged", v, 48'h0000_0000_0042);
    rdCmp(v); check("R10 compare unchanged", v, 48'h0000_0000_0099);
    rdSts(s); check("R10 status upper zero", s, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCount();
    tLoad();
    tCarry();
    tCompareRegs();
    tAlarm();
    tSetWins();
    tMask();
    tZeroCmp();
    tUnmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule